// File: doc/BRIEF.md
# Triangle-Carrier PWM Generator

This block produces a complementary pair of pulse-width-modulated signals. An up/down counter runs as a symmetric triangle carrier, and a stored 8-bit duty level is compared against it on every clock. Because the carrier is symmetric, the pulse is centred on each carrier valley. The high time of the primary output grows with the duty level.

Duty levels arrive as 32-bit instruction words qualified by a one-cycle load strobe. A word is taken only when its opcode field holds the PWM code. An accepted level waits in a shadow register and moves into the comparator only when the carrier returns to zero, so a period is never split between two levels. A one-clock valley pulse marks the start of every carrier period.

Top module: `tri_pwm_gen`

## Requirements
- R1: The carrier counts 0,1,...,255 and then 254,...,1, and then returns to 0. This repeats, so one full period is 510 clocks.
- R2: `valley` is high for exactly one clock in each period, in the clock where the carrier equals 0. Consecutive valley pulses are 510 clocks apart.
- R3: A word is accepted only when `load` is high and bits 4..0 equal 5'b11010. The duty level is then taken from bits 12..5. A word with any other opcode, or any word presented while `load` is low, leaves the stored level unchanged.
- R4: An accepted level is applied from the next valley clock onward. The output for the rest of the current period follows the previous level. A word accepted on the same clock edge on which the carrier enters 0 is applied one period later.
- R5: `pwm_a` is high exactly while the applied duty level is greater than the carrier. For a level d ≥ 1 this gives 2·d−1 high clocks per period, and 509 high clocks when d = 255.
- R6: `pwm_b` is always the complement of `pwm_a`.
- R7: With an applied duty level of 0, `pwm_a` stays low for the whole period.
- R8: Reset is synchronous and active high. It sets the carrier to 0 counting up, and sets the stored and applied levels to 0. After reset `pwm_a` is low, `pwm_b` is high and `valley` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Instruction word: opcode in bits 4..0, duty level in bits 12..5 |
| load | input | 1 | Qualifies `instr` for one clock |
| pwm_a | output | 1 | Primary PWM output |
| pwm_b | output | 1 | Complementary PWM output |
| valley | output | 1 | One-clock pulse while the carrier is 0 |

## Verification
The embedded assertions check a set of properties on every clock. These are the carrier turning points and the unit step on the rising slope, and the one-clock width of the valley pulse. They also cover the capture or retention of the shadow level according to opcode and strobe, the fact that the applied level changes only on entry to the valley, and the low output at zero duty and at the carrier peak. Some behaviour only the bench scenarios can show. These are the exact number of high clocks for every duty level from 0 to 255, and the one-period delay of a level loaded mid-period or on the edge entering the valley. They also include the rejection of mistagged or unstrobed words, measured at the outputs in the following period.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;

    localparam int unsigned INSTR_W_DEF = 32;
    localparam int unsigned LEVEL_W_DEF = 8;
    localparam int unsigned OPC_W       = 5;
    localparam int unsigned LEVEL_LSB   = 5;
    localparam logic [OPC_W-1:0] OPC_PWM = 5'b11010;

    typedef enum logic {
        SLOPE_UP   = 1'b0,
        SLOPE_DOWN = 1'b1
    } slope_e;

    function automatic logic opc_is_pwm(input logic [INSTR_W_DEF-1:0] word);
        return word[OPC_W-1:0] == OPC_PWM;
    endfunction

    function automatic logic [LEVEL_W_DEF-1:0] level_of(input logic [INSTR_W_DEF-1:0] word);
        return word[LEVEL_LSB +: LEVEL_W_DEF];
    endfunction

endpackage

// File: rtl/tpwm_carrier.sv
module tpwm_carrier
    import tpwm_pkg::*;
#(
    parameter int unsigned CNT_W = LEVEL_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] count,
    output slope_e           slope,
    output logic             at_valley,
    output logic             enter_valley
);

    localparam logic [CNT_W-1:0] PEAK = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            slope <= SLOPE_UP;
        end else begin
            unique case (slope)
                SLOPE_UP: begin
                    if (count == PEAK) begin
                        count <= PEAK - ONE;
                        slope <= SLOPE_DOWN;
                    end else begin
                        count <= count + ONE;
                    end
                end
                SLOPE_DOWN: begin
                    if (count == ONE) begin
                        count <= '0;
                        slope <= SLOPE_UP;
                    end else begin
                        count <= count - ONE;
                    end
                end
                default: begin
                    count <= '0;
                    slope <= SLOPE_UP;
                end
            endcase
        end
    end

    assign at_valley    = (count == '0);
    assign enter_valley = (slope == SLOPE_DOWN) && (count == ONE);

    // R1
    peak_turn_chk: assert property (@(posedge clk) disable iff (rst)
        (count == PEAK) |=> (count == PEAK - ONE));

    // R1
    valley_turn_chk: assert property (@(posedge clk) disable iff (rst)
        (count == '0) |=> (count == ONE));

    // R1
    rise_step_chk: assert property (@(posedge clk) disable iff (rst)
        (slope == SLOPE_UP && count != PEAK) |=> (count == CNT_W'($past(count) + ONE)));

endmodule

// File: rtl/tpwm_level.sv
module tpwm_level
    import tpwm_pkg::*;
#(
    parameter int unsigned INSTR_W = INSTR_W_DEF,
    parameter int unsigned LEVEL_W = LEVEL_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] instr,
    input  logic               load,
    input  logic               enter_valley,
    output logic [LEVEL_W-1:0] level_now
);

    logic [LEVEL_W-1:0] level_next;
    logic               take;
    logic [LEVEL_W-1:0] field;

    assign take  = load && (instr[OPC_W-1:0] == OPC_PWM);
    assign field = instr[LEVEL_LSB +: LEVEL_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            level_next <= '0;
        end else if (take) begin
            level_next <= field;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_now <= '0;
        end else if (enter_valley) begin
            level_now <= level_next;
        end
    end

    // R3
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        (load && instr[OPC_W-1:0] == OPC_PWM) |=> (level_next == $past(field)));

    // R3
    reject_chk: assert property (@(posedge clk) disable iff (rst)
        !(load && instr[OPC_W-1:0] == OPC_PWM) |=> $stable(level_next));

    // R4
    hold_midperiod_chk: assert property (@(posedge clk) disable iff (rst)
        !enter_valley |=> $stable(level_now));

    // R4
    apply_chk: assert property (@(posedge clk) disable iff (rst)
        enter_valley |=> (level_now == $past(level_next)));

endmodule

// File: rtl/tpwm_compare.sv
module tpwm_compare
    import tpwm_pkg::*;
#(
    parameter int unsigned LEVEL_W = LEVEL_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LEVEL_W-1:0] level_now,
    input  logic [LEVEL_W-1:0] count,
    output logic               pwm_a,
    output logic               pwm_b
);

    localparam logic [LEVEL_W-1:0] PEAK = {LEVEL_W{1'b1}};

    always_comb begin
        pwm_a = (level_now > count);
        pwm_b = ~pwm_a;
    end

    // R7
    zero_level_chk: assert property (@(posedge clk) disable iff (rst)
        (level_now == '0) |-> !pwm_a);

    // R5
    peak_low_chk: assert property (@(posedge clk) disable iff (rst)
        (count == PEAK) |-> !pwm_a);

endmodule

// File: rtl/tri_pwm_gen.sv
module tri_pwm_gen
    import tpwm_pkg::*;
#(
    parameter int unsigned INSTR_W = INSTR_W_DEF,
    parameter int unsigned LEVEL_W = LEVEL_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] instr,
    input  logic               load,
    output logic               pwm_a,
    output logic               pwm_b,
    output logic               valley
);

    logic [LEVEL_W-1:0] count;
    slope_e             slope;
    logic               enter_valley;
    logic [LEVEL_W-1:0] level_now;

    tpwm_carrier #(.CNT_W(LEVEL_W)) u_carrier (
        .clk          (clk),
        .rst          (rst),
        .count        (count),
        .slope        (slope),
        .at_valley    (valley),
        .enter_valley (enter_valley)
    );

    tpwm_level #(.INSTR_W(INSTR_W), .LEVEL_W(LEVEL_W)) u_level (
        .clk          (clk),
        .rst          (rst),
        .instr        (instr),
        .load         (load),
        .enter_valley (enter_valley),
        .level_now    (level_now)
    );

    tpwm_compare #(.LEVEL_W(LEVEL_W)) u_compare (
        .clk       (clk),
        .rst       (rst),
        .level_now (level_now),
        .count     (count),
        .pwm_a     (pwm_a),
        .pwm_b     (pwm_b)
    );

    // R2
    valley_width_chk: assert property (@(posedge clk) disable iff (rst)
        valley |=> !valley);

    // R6
    complement_chk: assert property (@(posedge clk) disable iff (rst)
        pwm_b != pwm_a);

endmodule

// File: tb/sim_tri_pwm_gen.sv
`timescale 1ns/1ps
module sim_tri_pwm_gen;

    localparam int PERIOD_CLKS = 510;
    localparam logic [4:0] OPC_OK  = 5'b11010;
    localparam logic [4:0] OPC_BAD = 5'b11011;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = '0;
    logic        load = 1'b0;
    logic        pwm_a, pwm_b, valley;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tri_pwm_gen u0 (
        .clk    (clk),
        .rst    (rst),
        .instr  (instr),
        .load   (load),
        .pwm_a  (pwm_a),
        .pwm_b  (pwm_b),
        .valley (valley)
    );

    function automatic logic [31:0] mk_word(input logic [4:0] opc, input int lvl);
        return {19'h0, 8'(lvl), opc};
    endfunction

    function automatic int hi_clocks(input int lvl);
        return (lvl == 0) ? 0 : 2 * lvl - 1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Starts at a negedge where the valley clock is being observed; ends at the next one.
    task automatic run_period(input int exp_hi, input string req, input bit drive,
                              input int off, input logic [31:0] word, input logic ld);
        int hi = 0;
        int comp_bad = 0;
        int valley_bad = 0;
        for (int i = 0; i < PERIOD_CLKS; i++) begin
            if (pwm_a) hi++;
            if (pwm_b == pwm_a) comp_bad++;
            if (valley != (i == 0)) valley_bad++;
            if (drive && i == off) begin
                instr = word;
                load  = ld;
            end else begin
                load  = 1'b0;
                instr = '0;
            end
            @(negedge clk);
        end
        check(hi == exp_hi, req, hi, exp_hi);
        check(comp_bad == 0, "R6 complement", comp_bad, 0);
        check(valley_bad == 0, "R1/R2 valley spacing", valley_bad, 0);
    endtask

    initial begin
        int prev;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8 reset state
        check(pwm_a == 1'b0, "R8 pwm_a", int'(pwm_a), 0);
        check(pwm_b == 1'b1, "R8 pwm_b", int'(pwm_b), 1);
        check(valley == 1'b1, "R8 valley", int'(valley), 1);

        // R7 zero duty after reset, load 10
        run_period(0, "R7 zero level", 1, 0, mk_word(OPC_OK, 10), 1'b1);
        // R5 level 10; wrong opcode with 200
        run_period(19, "R5 level 10", 1, 50, mk_word(OPC_BAD, 200), 1'b1);
        // R3 wrong opcode ignored; right opcode without strobe
        run_period(19, "R3 bad opcode ignored", 1, 60, mk_word(OPC_OK, 200), 1'b0);
        // R3 unstrobed ignored; load 100 on edge entering valley
        run_period(19, "R3 no strobe ignored", 1, PERIOD_CLKS - 1, mk_word(OPC_OK, 100), 1'b1);
        // R4 load on valley-entry edge waits one more period
        run_period(19, "R4 late load deferred", 0, 0, '0, 1'b0);
        // R4 now applied; load 0 mid-period
        run_period(199, "R4 applied next period", 1, 300, mk_word(OPC_OK, 0), 1'b1);

        // R5 sweep of all levels, each loaded one period ahead
        prev = 0;
        for (int d = 0; d < 256; d++) begin
            run_period(hi_clocks(prev), "R5 level sweep", 1, 200, mk_word(OPC_OK, d), 1'b1);
            prev = d;
        end
        // R5 full-scale level
        run_period(509, "R5 level 255", 0, 0, '0, 1'b0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule